// File: doc/BRIEF.md
# Chained Address/Data Watchpoint Pair

This block watches the bus traffic of a processor core with two watchpoint units. Each unit holds a value register and a mask register for the address, the data and the control lines. On every cycle that carries a valid transfer, each unit compares the live buses against its registers. A unit reports a hit when every bit whose mask bit is 0 agrees. For each unit, a control bit picks the buses it compares: the instruction-fetch side, or the data side. On the data side the unit compares read data or write data, following the direction of the transfer.

Unit 1's hit is a chain signal that feeds only unit 0. A small two-state arming machine sits between them, with states DISARMED and ARMED:
- DISARMED to ARMED: a valid cycle in which unit 1 hits.
- ARMED to DISARMED: a register write, or a trigger of unit 0 without a unit 1 hit in the same cycle.
- All other cycles: the state holds.

With chaining enabled, unit 0 may only trigger while the machine is ARMED, that is after an earlier unit 1 hit. With range mode enabled, unit 0 triggers only when unit 1 also hits in the same cycle. Software programs the registers through a simple write port. Both match outputs are registered pulses.

Top module: `wp_pair`

## Requirements
- R1: After reset all twelve registers are zero, both match outputs are low and the machine is DISARMED. With all buses at zero, a valid cycle makes both units hit.
- R2: A mask bit of 1 removes that bit from the compare. A mask bit of 0 requires the bus bit to equal the value bit. This holds for the address, data and control fields.
- R3: When control value bit 3 of a unit is 0, that unit compares `if_addr` and `if_instr`. When the bit is 1, it compares `dt_addr` and the data bus chosen by the direction: `dt_wdata` when `dt_is_write` is 1, otherwise `dt_rdata`.
- R4: Control value bits [2:0] are compared with `cbus[2:0]` and bits [6:4] with `cbus[6:4]`, each under the control mask bit of the same index. `cbus[3]` and `cbus[9:7]` are never compared.
- R5: A match output rises one clock after a valid cycle that qualifies, and stays high for one clock unless the next cycle also qualifies. A cycle with `bus_valid` low produces no match.
- R6: Unit 1 hits only when its address part and its data part both agree. The address part covers address and control bits [2:0]. The data part covers data and control bits [6:4].
- R7: When unit 0's control value bit 8 (chain enable) is 1, unit 0 triggers only in the ARMED state. A unit 1 hit in the same cycle does not count. When the bit is 0, unit 0 triggers on its own hit.
- R8: A unit 0 trigger moves ARMED to DISARMED, except when unit 1 hits in the same cycle, in which case the machine stays ARMED.
- R9: Any register write returns the machine to DISARMED, and a write takes priority over a unit 1 hit in the same cycle.
- R10: When unit 0's control value bit 7 (range enable) is 1, unit 0 triggers only in a cycle where unit 1 also hits.
- R11: Unit 1 ignores its own control value bits 7 and 8. Its output never depends on the arming state.
- R12: A write stores `wr_data` in the register of unit `wr_unit` chosen by `wr_sel`: 0 address value, 1 address mask, 2 data value, 3 data mask, 4 control value, 5 control mask. Codes 6 and 7 store nothing but still disarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_unit | input | 1 | Unit selected by a write |
| wr_sel | input | 3 | Register selected by a write |
| wr_data | input | 32 | Write data |
| bus_valid | input | 1 | Transfer strobe; compares count only when high |
| if_addr | input | 32 | Instruction-fetch address |
| if_instr | input | 32 | Fetched instruction word |
| dt_addr | input | 32 | Data-side address |
| dt_rdata | input | 32 | Data-side read data |
| dt_wdata | input | 32 | Data-side write data |
| dt_is_write | input | 1 | 1 for a data write, 0 for a read |
| cbus | input | 10 | Control lines compared against the control value |
| match0_o | output | 1 | Unit 0 trigger pulse |
| match1_o | output | 1 | Unit 1 hit pulse (chain source) |

## Verification
The functions that can collide are the unit 0 trigger, which disarms the machine, and the unit 1 hit, which arms it. They can fall in the same valid cycle. The bench provokes this with chaining on: it makes unit 0 match on the fetch address and unit 1 match on the instruction word at the same moment while the machine is ARMED. It judges the outcome by the next cycle, in which unit 0 alone must still trigger. A second collision, a register write during a unit 1 hit, is judged by unit 0 staying silent afterwards.

// File: rtl/wp_pkg.sv
package wp_pkg;

    localparam int CV_W = 9;
    localparam int CM_W = 8;
    localparam int CB_W = 10;

    localparam int BIT_DSEL  = 3;
    localparam int BIT_RANGE = 7;
    localparam int BIT_CHAIN = 8;

    localparam int AC_LO = 0;
    localparam int AC_HI = 2;
    localparam int DC_LO = 4;
    localparam int DC_HI = 6;

    typedef enum logic [2:0] {
        SEL_AVAL = 3'd0,
        SEL_AMSK = 3'd1,
        SEL_DVAL = 3'd2,
        SEL_DMSK = 3'd3,
        SEL_CVAL = 3'd4,
        SEL_CMSK = 3'd5
    } reg_sel_e;

    typedef enum logic {
        ST_DISARMED = 1'b0,
        ST_ARMED    = 1'b1
    } arm_state_e;

endpackage

// File: rtl/wp_regs.sv
module wp_regs
    import wp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int WR_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [2:0]        sel,
    input  logic [WR_W-1:0]   wdat,
    output logic [ADDR_W-1:0] aval,
    output logic [ADDR_W-1:0] amsk,
    output logic [DATA_W-1:0] dval,
    output logic [DATA_W-1:0] dmsk,
    output logic [CV_W-1:0]   cval,
    output logic [CM_W-1:0]   cmsk
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            aval <= '0;
            amsk <= '0;
            dval <= '0;
            dmsk <= '0;
            cval <= '0;
            cmsk <= '0;
        end else if (we) begin
            unique case (sel)
                SEL_AVAL: aval <= ADDR_W'(wdat);
                SEL_AMSK: amsk <= ADDR_W'(wdat);
                SEL_DVAL: dval <= DATA_W'(wdat);
                SEL_DMSK: dmsk <= DATA_W'(wdat);
                SEL_CVAL: cval <= wdat[CV_W-1:0];
                SEL_CMSK: cmsk <= wdat[CM_W-1:0];
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/wp_compare.sv
module wp_compare
    import wp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0] aval,
    input  logic [ADDR_W-1:0] amsk,
    input  logic [DATA_W-1:0] dval,
    input  logic [DATA_W-1:0] dmsk,
    input  logic [CV_W-1:0]   cval,
    input  logic [CM_W-1:0]   cmsk,
    input  logic [ADDR_W-1:0] if_addr,
    input  logic [DATA_W-1:0] if_instr,
    input  logic [ADDR_W-1:0] dt_addr,
    input  logic [DATA_W-1:0] dt_rdata,
    input  logic [DATA_W-1:0] dt_wdata,
    input  logic              dt_is_write,
    input  logic [CB_W-1:0]   cbus,
    output logic              hit
);

    localparam int ACW = AC_HI - AC_LO + 1;
    localparam int DCW = DC_HI - DC_LO + 1;

    logic [ADDR_W-1:0] a_bus;
    logic [DATA_W-1:0] d_bus;
    logic [ACW-1:0]    ac_ok;
    logic [DCW-1:0]    dc_ok;
    logic              a_part;
    logic              d_part;

    always_comb begin
        if (cval[BIT_DSEL]) begin
            a_bus = dt_addr;
            d_bus = dt_is_write ? dt_wdata : dt_rdata;
        end else begin
            a_bus = if_addr;
            d_bus = if_instr;
        end
    end

    assign ac_ok  = (cval[AC_HI:AC_LO] ~^ cbus[AC_HI:AC_LO]) | cmsk[AC_HI:AC_LO];
    assign dc_ok  = (cval[DC_HI:DC_LO] ~^ cbus[DC_HI:DC_LO]) | cmsk[DC_HI:DC_LO];
    assign a_part = (&((aval ~^ a_bus) | amsk)) & (&ac_ok);
    assign d_part = (&((dval ~^ d_bus) | dmsk)) & (&dc_ok);
    assign hit    = a_part & d_part;

endmodule

// File: rtl/wp_arm_fsm.sv
module wp_arm_fsm
    import wp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_valid,
    input  logic wr_en,
    input  logic hit0,
    input  logic chain_in,
    input  logic chain_en,
    input  logic range_en,
    output logic armed,
    output logic match0_o,
    output logic match1_o
);

    arm_state_e state, nxt;
    logic fire0, fire1, gate0;

    assign armed = (state == ST_ARMED);
    assign gate0 = (!chain_en || armed) && (!range_en || chain_in);
    assign fire0 = bus_valid && hit0 && gate0;
    assign fire1 = bus_valid && chain_in;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_DISARMED: begin
                if (!wr_en && fire1) nxt = ST_ARMED;
            end
            ST_ARMED: begin
                if (wr_en)      nxt = ST_DISARMED;
                else if (fire1) nxt = ST_ARMED;
                else if (fire0) nxt = ST_DISARMED;
            end
            default: nxt = ST_DISARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_DISARMED;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match0_o <= 1'b0;
            match1_o <= 1'b0;
        end else begin
            match0_o <= fire0;
            match1_o <= fire1;
        end
    end

endmodule

// File: rtl/wp_pair.sv
module wp_pair
    import wp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int WR_W   = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_unit,
    input  logic [2:0]        wr_sel,
    input  logic [WR_W-1:0]   wr_data,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] if_addr,
    input  logic [DATA_W-1:0] if_instr,
    input  logic [ADDR_W-1:0] dt_addr,
    input  logic [DATA_W-1:0] dt_rdata,
    input  logic [DATA_W-1:0] dt_wdata,
    input  logic              dt_is_write,
    input  logic [CB_W-1:0]   cbus,
    output logic              match0_o,
    output logic              match1_o
);

    localparam int N_UNITS = 2;

    logic [N_UNITS-1:0] hit;
    logic [CV_W-1:0]    cval0;
    logic               chain_en, range_en, armed;

    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        logic [ADDR_W-1:0] aval, amsk;
        logic [DATA_W-1:0] dval, dmsk;
        logic [CV_W-1:0]   cval;
        logic [CM_W-1:0]   cmsk;

        wp_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_W(WR_W)) regs_i (
            .clk  (clk),
            .rst_n(rst_n),
            .we   (wr_en && (wr_unit == 1'(u))),
            .sel  (wr_sel),
            .wdat (wr_data),
            .aval (aval),
            .amsk (amsk),
            .dval (dval),
            .dmsk (dmsk),
            .cval (cval),
            .cmsk (cmsk)
        );

        wp_compare #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) cmp_i (
            .aval       (aval),
            .amsk       (amsk),
            .dval       (dval),
            .dmsk       (dmsk),
            .cval       (cval),
            .cmsk       (cmsk),
            .if_addr    (if_addr),
            .if_instr   (if_instr),
            .dt_addr    (dt_addr),
            .dt_rdata   (dt_rdata),
            .dt_wdata   (dt_wdata),
            .dt_is_write(dt_is_write),
            .cbus       (cbus),
            .hit        (hit[u])
        );
    end

    assign cval0    = g_unit[0].cval;
    assign chain_en = cval0[BIT_CHAIN];
    assign range_en = cval0[BIT_RANGE];

    wp_arm_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_valid(bus_valid),
        .wr_en    (wr_en),
        .hit0     (hit[0]),
        .chain_in (hit[1]),
        .chain_en (chain_en),
        .range_en (range_en),
        .armed    (armed),
        .match0_o (match0_o),
        .match1_o (match1_o)
    );

endmodule

// File: rtl/wp_pair_chk.sv
module wp_pair_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_valid,
    input logic wr_en,
    input logic hit0,
    input logic hit1,
    input logic armed,
    input logic chain_en,
    input logic range_en,
    input logic match0_o,
    input logic match1_o
);

    a_r5_idle_no_match: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> (!match0_o && !match1_o));

    a_r6_unit1_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && hit1) |=> match1_o);

    a_r7_chain_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && chain_en && !armed) |=> !match0_o);

    a_r8_trigger_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && hit0 && armed && !hit1 && !wr_en && !range_en) |=> !armed);

    a_r8_unit1_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && hit1 && !wr_en) |=> armed);

    a_r9_write_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !armed);

    a_r10_range_needs_unit1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && range_en && !hit1) |=> !match0_o);

endmodule

bind wp_pair wp_pair_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_valid(bus_valid),
    .wr_en    (wr_en),
    .hit0     (hit[0]),
    .hit1     (hit[1]),
    .armed    (armed),
    .chain_en (chain_en),
    .range_en (range_en),
    .match0_o (match0_o),
    .match1_o (match1_o)
);

// File: tb/wp_pair_tb_top.sv
module wp_pair_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_unit = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        bus_valid = 1'b0;
    logic [31:0] if_addr = '0, if_instr = '0, dt_addr = '0, dt_rdata = '0, dt_wdata = '0;
    logic        dt_is_write = 1'b0;
    logic [9:0]  cbus = '0;
    logic        match0_o, match1_o;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    wp_pair dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_unit(wr_unit), .wr_sel(wr_sel),
        .wr_data(wr_data), .bus_valid(bus_valid), .if_addr(if_addr), .if_instr(if_instr),
        .dt_addr(dt_addr), .dt_rdata(dt_rdata), .dt_wdata(dt_wdata),
        .dt_is_write(dt_is_write), .cbus(cbus), .match0_o(match0_o), .match1_o(match1_o)
    );

    task automatic check(input logic e0, input logic e1, input string req);
        n_chk++;
        if (match0_o !== e0 || match1_o !== e1) begin
            n_fail++;
            $display("FAIL %s: match0/match1 actual %b%b expected %b%b", req, match0_o, match1_o, e0, e1);
        end
    endtask

    task automatic wr(input logic u, input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b0;
        wr_en = 1'b1; wr_unit = u; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic prog(input logic u, input logic [31:0] av, am, dv, dm,
                        input logic [8:0] cv, input logic [7:0] cm);
        wr(u, 3'd0, av); wr(u, 3'd1, am); wr(u, 3'd2, dv);
        wr(u, 3'd3, dm); wr(u, 3'd4, {23'd0, cv}); wr(u, 3'd5, {24'd0, cm});
    endtask

    // one transfer cycle; v selects bus_valid; outputs checked after the capturing edge
    task automatic cyc(input logic v, input logic [31:0] ia, ins, da, rd, wd,
                       input logic w, input logic [9:0] cb,
                       input logic e0, input logic e1, input string req);
        @(negedge clk);
        bus_valid = v; if_addr = ia; if_instr = ins; dt_addr = da;
        dt_rdata = rd; dt_wdata = wd; dt_is_write = w; cbus = cb;
        @(posedge clk);
        #1;
        check(e0, e1, req);
    endtask

    task automatic t_reset;
        check(1'b0, 1'b0, "R1 outputs low in reset");
        @(negedge clk); rst_n = 1'b1;
        cyc(1, 0, 0, 0, 0, 0, 0, 10'h000, 1, 1, "R1 zero registers hit zero buses");
    endtask

    task automatic t_mask;
        prog(0, 32'hDEAD_0000, 0, 0, 32'hFFFF_FFFF, 0, 8'hFF);
        prog(1, 32'h1000_0000, 32'h0000_00FF, 0, 32'hFFFF_FFFF, 0, 8'hFF);
        cyc(1, 32'h1000_0042, 0, 0, 0, 0, 0, 0, 0, 1, "R2 masked low byte ignored");
        cyc(1, 32'h1000_0142, 0, 0, 0, 0, 0, 0, 0, 0, "R2 unmasked bit differs");
        cyc(1, 32'h1000_00FF, 0, 0, 0, 0, 0, 0, 0, 1, "R5 repeated qualifying cycle");
        cyc(0, 32'h1000_00FF, 0, 0, 0, 0, 0, 0, 0, 0, "R5 no match without bus_valid");
    endtask

    task automatic t_select;
        prog(1, 32'h0000_2000, 0, 32'h55, 0, 9'h008, 8'hFF);
        cyc(1, 0, 0, 32'h2000, 32'h55, 0, 0, 0, 0, 1, "R3 data side read");
        cyc(1, 0, 0, 32'h2000, 0, 32'h55, 1, 0, 0, 1, "R3 data side write");
        cyc(1, 0, 0, 32'h2000, 32'h55, 0, 1, 0, 0, 0, "R3 write uses wdata not rdata");
        cyc(1, 32'h2000, 32'h55, 0, 32'h55, 0, 0, 0, 0, 0, "R3 fetch side ignored when bit3 set");
        prog(1, 0, 32'hFFFF_FFFF, 32'h77, 0, 9'h000, 8'hFF);
        cyc(1, 0, 32'h77, 0, 0, 0, 0, 0, 0, 1, "R3 instruction word compared");
        cyc(1, 0, 32'h78, 0, 32'h77, 0, 0, 0, 0, 0, "R3 instruction mismatch");
    endtask

    task automatic t_ctrl;
        prog(1, 0, 32'hFFFF_FFFF, 0, 32'hFFFF_FFFF, 9'h053, 8'h00);
        cyc(1, 0, 0, 0, 0, 0, 0, 10'h053, 0, 1, "R4 control equal");
        cyc(1, 0, 0, 0, 0, 0, 0, 10'h3DB, 0, 1, "R4 cbus bits 3 and 9:7 not compared");
        cyc(1, 0, 0, 0, 0, 0, 0, 10'h052, 0, 0, "R4 address-part control bit differs");
        cyc(1, 0, 0, 0, 0, 0, 0, 10'h043, 0, 0, "R4 data-part control bit differs");
        wr(1, 3'd5, 32'h01);
        cyc(1, 0, 0, 0, 0, 0, 0, 10'h052, 0, 1, "R2 control mask bit ignores bit 0");
        prog(1, 32'h300, 0, 32'h9, 0, 0, 8'hFF);
        cyc(1, 32'h300, 32'h8, 0, 0, 0, 0, 0, 0, 0, "R6 address agrees, data differs");
        cyc(1, 32'h301, 32'h9, 0, 0, 0, 0, 0, 0, 0, "R6 data agrees, address differs");
        cyc(1, 32'h300, 32'h9, 0, 0, 0, 0, 0, 0, 1, "R6 both parts agree");
    endtask

    task automatic t_chain;
        prog(1, 0, 32'hFFFF_FFFF, 32'h11, 0, 9'h000, 8'hFF);
        prog(0, 32'hA0, 0, 0, 32'hFFFF_FFFF, 9'h100, 8'hFF);
        cyc(1, 32'hA0, 0, 0, 0, 0, 0, 0, 0, 0, "R7 chained unit 0 blocked while disarmed");
        cyc(1, 32'hA0, 32'h11, 0, 0, 0, 0, 0, 0, 1, "R7 same-cycle unit 1 hit does not count");
        cyc(1, 32'hA0, 32'h11, 0, 0, 0, 0, 0, 1, 1, "R8 trigger with unit 1 hit in same cycle");
        cyc(1, 32'hA0, 0, 0, 0, 0, 0, 0, 1, 0, "R8 still armed after coincident hit");
        cyc(1, 32'hA0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 trigger disarmed the chain");
        cyc(1, 0, 32'h11, 0, 0, 0, 0, 0, 0, 1, "R7 arm again");
        wr(0, 3'd6, 32'h0);
        cyc(1, 32'hA0, 0, 0, 0, 0, 0, 0, 0, 0, "R12 R9 unused code stores nothing but disarms");
        cyc(1, 0, 32'h11, 0, 0, 0, 0, 0, 0, 1, "R7 arm before write collision");
        @(negedge clk);
        wr_en = 1'b1; wr_unit = 1'b1; wr_sel = 3'd5; wr_data = 32'hFF;
        bus_valid = 1'b1; if_addr = 0; if_instr = 32'h11;
        @(posedge clk); #1;
        check(1'b0, 1'b1, "R9 write during unit 1 hit");
        @(negedge clk); wr_en = 1'b0; bus_valid = 1'b0;
        cyc(1, 32'hA0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 write beat unit 1 hit");
        wr(0, 3'd4, 32'h0);
        cyc(1, 32'hA0, 0, 0, 0, 0, 0, 0, 1, 0, "R7 unchained unit 0 fires alone");
    endtask

    task automatic t_range;
        prog(0, 32'hA0, 0, 0, 32'hFFFF_FFFF, 9'h080, 8'hFF);
        cyc(1, 32'hA0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 range needs unit 1");
        cyc(1, 32'hA0, 32'h11, 0, 0, 0, 0, 0, 1, 1, "R10 both units in range");
        cyc(1, 0, 32'h11, 0, 0, 0, 0, 0, 0, 1, "R10 unit 1 alone");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R5 pulse ends");
    endtask

    task automatic t_unit1_ctrl;
        prog(1, 0, 32'hFFFF_FFFF, 32'h11, 0, 9'h180, 8'hFF);
        prog(0, 32'hDEAD_0000, 0, 0, 0, 0, 8'hFF);
        cyc(1, 0, 32'h11, 0, 0, 0, 0, 0, 0, 1, "R11 unit 1 ignores its bits 7 and 8");
        cyc(1, 0, 32'h10, 0, 0, 0, 0, 0, 0, 0, "R11 unit 1 still compares");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired (R5 timing never completed)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_mask();
        t_select();
        t_ctrl();
        t_chain();
        t_range();
        t_unit1_ctrl();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule